// File: doc/BRIEF.md
# Operate Microinstruction Execution Unit

This block carries out the register-only "operate" instructions of a 12-bit accumulator machine. It holds a 1-bit link, a word-wide accumulator and a word-wide multiplier-quotient register. It applies the micro-operations packed into one instruction word to these registers in a fixed order, spread over three phase cycles. The surrounding processor owns fetch, memory and the program counter. It hands the unit the instruction, the current link, accumulator and MQ values, the front-panel switch value and the user-mode flag, all with a one-cycle `start` strobe. It then collects the updated registers when `done` pulses.

Instruction bits 8 and 0 pick one of three groups. Bits 11:9 are not examined. The first group does clear and complement operations, a 13-bit increment of link:accumulator, and a rotate or half-word swap. The second group does conditional skips, accumulator clear, the switch read and halt. In user mode the switch read and the halt are converted into a trap. The third group moves data between the accumulator and MQ. The unit reports skip, halt and trap requests together with the results. Those flags stay valid until the next accepted `start`.

Top module: `opr_unit`

## Requirements
- R1: After reset, `link_out`, `ac_out`, `mq_out`, `skip_req`, `halt_req`, `user_trap`, `busy` and `done` are all 0.
- R2: Group 1 is selected by bit 8 = 0. Its first phase applies, in this order: bit 7 clears AC, bit 6 clears L, bit 5 complements AC, and bit 4 complements L. For example, clear and complement together leave AC all ones.
- R3: In group 1, bit 0 adds one to the 13-bit value {L, AC} in the second phase. This is after the first-phase operations and before the rotate, so a carry out of AC toggles L into 1 from 0.
- R4: In group 1, the field in bits 3:1 selects the third-phase operation. Code 1 swaps the two half-words of AC. Code 2 rotates {L, AC} left by one. Code 3 rotates it left by two. Code 4 rotates it right by one. Code 5 rotates it right by two. Codes 0, 6 and 7 leave L and AC unchanged.
- R5: Group 2 is selected by bit 8 = 1 and bit 0 = 0. The condition is the OR of three terms: AC bit 11 when bit 6 is set, AC equal to zero when bit 5 is set, and L when bit 4 is set. `skip_req` is set when this condition differs from bit 3. The condition uses the L and AC values from before this instruction's clear. Groups 1 and 3 never set `skip_req`.
- R6: In group 2, bit 7 clears AC in the first phase. Outside user mode, bit 2 then ORs the switch value captured at `start` into AC in the second phase.
- R7: In group 2, bit 1 sets `halt_req` when the unit is not in user mode.
- R8: In group 2 in user mode, bit 2 or bit 1 sets `user_trap`. In that case `halt_req` stays 0 and AC is not ORed with the switches.
- R9: Group 3 is selected by bit 8 = 1 and bit 0 = 1. Bit 7 clears AC in the first phase. Then bits 6:4 select the transfer: code 1 copies AC into MQ, code 2 ORs MQ into AC, and codes 4 and 5 copy MQ into AC. Other codes do no transfer.
- R10: In group 3, when bits 7:4 equal binary 1110, MQ is cleared in the third phase, after the transfer step.
- R11: A `start` seen while idle is accepted on that edge. `done` is high for exactly one cycle, in the fourth cycle after the accepting edge, and the results are final when it is high. `busy` is high from the accepting edge until `done` falls. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the operands below and begin |
| instr | input | 12 | Operate instruction word |
| switches | input | W | Front-panel switch value |
| user_mode | input | 1 | User-mode flag |
| link_in | input | 1 | Link value before the instruction |
| ac_in | input | W | Accumulator before the instruction |
| mq_in | input | W | MQ before the instruction |
| link_out | output | 1 | Link register |
| ac_out | output | W | Accumulator register |
| mq_out | output | W | MQ register |
| skip_req | output | 1 | Skip request for the program counter |
| halt_req | output | 1 | Halt request |
| user_trap | output | 1 | User-mode trap request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to bring about are those where the order of micro-operations is visible at the ports. Operand values are picked so that any other order gives a different answer. One case increments 0077 and then swaps it; swapping first would give a distinct word. Another combines a sign-test skip with a clear on a negative accumulator, so a test made after the clear would not skip. A third clears and complements together, where the reverse order gives zero. A second `start` carrying different operands is also driven in the middle of an instruction, and the results are checked to be untouched by it.

// File: rtl/opr_pkg.sv
package opr_pkg;

  typedef enum logic [1:0] {
    GRP_ONE   = 2'd0,
    GRP_TWO   = 2'd1,
    GRP_THREE = 2'd2
  } opr_grp_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PH1  = 3'd1,
    ST_PH2  = 3'd2,
    ST_PH3  = 3'd3,
    ST_FIN  = 3'd4
  } opr_state_e;

  // Decoded micro-operation enables; fields of other groups read as 0.
  typedef struct packed {
    opr_grp_e   grp;
    logic       clr_acc;
    logic       clr_lnk;
    logic       inv_acc;
    logic       inv_lnk;
    logic       inc;
    logic [2:0] rot;
    logic       t_neg;
    logic       t_zero;
    logic       t_lnk;
    logic       t_inv;
    logic       sw_or;
    logic       stop;
    logic [2:0] xfer;
    logic       mq_wipe;
  } opr_dec_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [11:0] instr,
  output opr_dec_t    dec
);

  always_comb begin
    dec = '0;
    if (!instr[8]) begin
      dec.grp     = GRP_ONE;
      dec.clr_acc = instr[7];
      dec.clr_lnk = instr[6];
      dec.inv_acc = instr[5];
      dec.inv_lnk = instr[4];
      dec.rot     = instr[3:1];
      dec.inc     = instr[0];
    end else if (!instr[0]) begin
      dec.grp     = GRP_TWO;
      dec.clr_acc = instr[7];
      dec.t_neg   = instr[6];
      dec.t_zero  = instr[5];
      dec.t_lnk   = instr[4];
      dec.t_inv   = instr[3];
      dec.sw_or   = instr[2];
      dec.stop    = instr[1];
    end else begin
      dec.grp     = GRP_THREE;
      dec.clr_acc = instr[7];
      dec.xfer    = instr[6:4];
      dec.mq_wipe = (instr[7:4] == 4'b1110);
    end
  end

endmodule

// File: rtl/opr_sequencer.sv
module opr_sequencer
  import opr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic ev_p1,
  output logic ev_p2,
  output logic ev_p3,
  output logic busy,
  output logic done
);

  opr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_PH1;
      ST_PH1:  state_d = ST_PH2;
      ST_PH2:  state_d = ST_PH3;
      ST_PH3:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load  = start && (state_q == ST_IDLE);
  assign ev_p1 = (state_q == ST_PH1);
  assign ev_p2 = (state_q == ST_PH2);
  assign ev_p3 = (state_q == ST_PH3);
  assign done  = (state_q == ST_FIN);
  assign busy  = (state_q != ST_IDLE);

  // R11: phases follow one another, completion is a single pulse
  p_phase12_r11: assert property (@(posedge clk) disable iff (!rst_n) ev_p1 |=> ev_p2);
  p_phase23_r11: assert property (@(posedge clk) disable iff (!rst_n) ev_p2 |=> ev_p3);
  p_phase3d_r11: assert property (@(posedge clk) disable iff (!rst_n) ev_p3 |=> done);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_load_idle_r11: assert property (@(posedge clk) disable iff (!rst_n) load |=> ev_p1);

endmodule

// File: rtl/opr_datapath.sv
module opr_datapath
  import opr_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         ev_p1,
  input  logic         ev_p2,
  input  logic         ev_p3,
  input  opr_dec_t     dec_in,
  input  logic [W-1:0] switches,
  input  logic         user_mode,
  input  logic         link_in,
  input  logic [W-1:0] ac_in,
  input  logic [W-1:0] mq_in,
  output logic         link_out,
  output logic [W-1:0] ac_out,
  output logic [W-1:0] mq_out,
  output logic         skip_req,
  output logic         halt_req,
  output logic         user_trap
);

  localparam int HALF = W / 2;
  localparam int LW   = W + 1;

  function automatic logic [LW-1:0] f_rotate(input logic [LW-1:0] v, input logic [2:0] code);
    case (code)
      3'd1:    f_rotate = {v[W], v[HALF-1:0], v[W-1:HALF]};
      3'd2:    f_rotate = {v[W-1:0], v[W]};
      3'd3:    f_rotate = {v[W-2:0], v[W:W-1]};
      3'd4:    f_rotate = {v[0], v[W:1]};
      3'd5:    f_rotate = {v[1:0], v[W:2]};
      default: f_rotate = v;
    endcase
  endfunction

  function automatic logic [LW-1:0] f_incr(input logic [LW-1:0] v);
    f_incr = v + {{(LW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic f_skip(input logic l, input logic [W-1:0] a, input opr_dec_t d);
    logic cond;
    cond = (d.t_neg && a[W-1]) || (d.t_zero && (a == '0)) || (d.t_lnk && l);
    f_skip = cond ^ d.t_inv;
  endfunction

  function automatic logic [W-1:0] f_xfer(input logic [W-1:0] a, input logic [W-1:0] m,
                                          input logic [2:0] code);
    case (code)
      3'd2:       f_xfer = a | m;
      3'd4, 3'd5: f_xfer = m;
      default:    f_xfer = a;
    endcase
  endfunction

  opr_dec_t     dec_q;
  logic         user_q;
  logic [W-1:0] sw_q;
  logic         l_q, skip_q, halt_q, trap_q;
  logic [W-1:0] ac_q, mq_q;

  logic         l_d, skip_d, halt_d, trap_d;
  logic [W-1:0] ac_d, mq_d;
  logic [LW-1:0] lac_tmp;

  // named internal events
  logic g1, g2, g3;
  logic ev_skip_eval, ev_priv, ev_trap, ev_mq_wipe;

  assign g1 = (dec_q.grp == GRP_ONE);
  assign g2 = (dec_q.grp == GRP_TWO);
  assign g3 = (dec_q.grp == GRP_THREE);
  assign ev_skip_eval = ev_p1 && g2;
  assign ev_priv      = ev_p2 && g2 && !user_q;
  assign ev_trap      = ev_p2 && g2 && user_q && (dec_q.sw_or || dec_q.stop);
  assign ev_mq_wipe   = ev_p3 && g3 && dec_q.mq_wipe;

  always_comb begin
    l_d     = l_q;
    ac_d    = ac_q;
    mq_d    = mq_q;
    skip_d  = skip_q;
    halt_d  = halt_q;
    trap_d  = trap_q;
    lac_tmp = {l_q, ac_q};
    if (ev_p1) begin
      if (ev_skip_eval) skip_d = f_skip(l_q, ac_q, dec_q);
      if (dec_q.clr_acc) ac_d = '0;
      if (dec_q.clr_lnk) l_d = 1'b0;
      if (dec_q.inv_acc) ac_d = ~ac_d;
      if (dec_q.inv_lnk) l_d = ~l_d;
    end else if (ev_p2) begin
      if (g1 && dec_q.inc) begin
        lac_tmp = f_incr({l_q, ac_q});
        l_d     = lac_tmp[W];
        ac_d    = lac_tmp[W-1:0];
      end
      if (ev_priv) begin
        if (dec_q.sw_or) ac_d = ac_q | sw_q;
        if (dec_q.stop)  halt_d = 1'b1;
      end
      if (ev_trap) trap_d = 1'b1;
      if (g3) begin
        if (dec_q.xfer == 3'd1) mq_d = ac_q;
        ac_d = f_xfer(ac_q, mq_q, dec_q.xfer);
      end
    end else if (ev_p3) begin
      if (g1) begin
        lac_tmp = f_rotate({l_q, ac_q}, dec_q.rot);
        l_d     = lac_tmp[W];
        ac_d    = lac_tmp[W-1:0];
      end
      if (ev_mq_wipe) mq_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      user_q <= 1'b0;
      sw_q   <= '0;
      l_q    <= 1'b0;
      ac_q   <= '0;
      mq_q   <= '0;
      skip_q <= 1'b0;
      halt_q <= 1'b0;
      trap_q <= 1'b0;
    end else if (load) begin
      dec_q  <= dec_in;
      user_q <= user_mode;
      sw_q   <= switches;
      l_q    <= link_in;
      ac_q   <= ac_in;
      mq_q   <= mq_in;
      skip_q <= 1'b0;
      halt_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      l_q    <= l_d;
      ac_q   <= ac_d;
      mq_q   <= mq_d;
      skip_q <= skip_d;
      halt_q <= halt_d;
      trap_q <= trap_d;
    end
  end

  assign link_out  = l_q;
  assign ac_out    = ac_q;
  assign mq_out    = mq_q;
  assign skip_req  = skip_q;
  assign halt_req  = halt_q;
  assign user_trap = trap_q;

  // R2: clear comes before complement within the first phase
  p_clear_then_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_p1 && g1 && dec_q.clr_acc && dec_q.inv_acc) |=> (ac_q == {W{1'b1}}));
  // R5: only the skip group may request a skip
  p_skip_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> g2);
  // R5: sign test sees the accumulator from before its clear
  p_skip_pre_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_skip_eval && dec_q.t_neg && !dec_q.t_inv && dec_q.clr_acc && ac_q[W-1])
    |=> (skip_q && ac_q == '0));
  // R7 / R8: halt is never raised in user mode
  p_halt_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !user_q);
  // R8: a trapped instruction leaves the accumulator alone
  p_trap_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> (trap_q && !halt_q && $stable(ac_q)));
  // R10: MQ wipe lands in the last phase
  p_mq_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mq_wipe |=> (mq_q == '0));

endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [11:0]  instr,
  input  logic [W-1:0] switches,
  input  logic         user_mode,
  input  logic         link_in,
  input  logic [W-1:0] ac_in,
  input  logic [W-1:0] mq_in,
  output logic         link_out,
  output logic [W-1:0] ac_out,
  output logic [W-1:0] mq_out,
  output logic         skip_req,
  output logic         halt_req,
  output logic         user_trap,
  output logic         busy,
  output logic         done
);

  opr_dec_t dec;
  logic load, ev_p1, ev_p2, ev_p3;

  opr_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  opr_sequencer u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .ev_p1 (ev_p1),
    .ev_p2 (ev_p2),
    .ev_p3 (ev_p3),
    .busy  (busy),
    .done  (done)
  );

  opr_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ev_p1     (ev_p1),
    .ev_p2     (ev_p2),
    .ev_p3     (ev_p3),
    .dec_in    (dec),
    .switches  (switches),
    .user_mode (user_mode),
    .link_in   (link_in),
    .ac_in     (ac_in),
    .mq_in     (mq_in),
    .link_out  (link_out),
    .ac_out    (ac_out),
    .mq_out    (mq_out),
    .skip_req  (skip_req),
    .halt_req  (halt_req),
    .user_trap (user_trap)
  );

  // R11: a busy unit stays busy when a new start arrives mid-run
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

endmodule

// File: tb/opr_unit_bench.sv
module opr_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] switches = '0;
  logic        user_mode = 1'b0;
  logic        link_in = 1'b0;
  logic [11:0] ac_in = '0;
  logic [11:0] mq_in = '0;
  logic        link_out, skip_req, halt_req, user_trap, busy, done;
  logic [11:0] ac_out, mq_out;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opr_unit #(.W(12)) u_opr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .switches(switches),
    .user_mode(user_mode), .link_in(link_in), .ac_in(ac_in), .mq_in(mq_in),
    .link_out(link_out), .ac_out(ac_out), .mq_out(mq_out), .skip_req(skip_req),
    .halt_req(halt_req), .user_trap(user_trap), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  endtask

  // Issue one instruction and check timing (R11) and results.
  task automatic run_op(input string tag, input logic [11:0] op, input logic [11:0] sw,
                        input logic usr, input logic l0, input logic [11:0] a0,
                        input logic [11:0] m0, input logic el, input logic [11:0] ea,
                        input logic [11:0] em, input logic esk, input logic eh,
                        input logic et, input bit intrude);
    @(negedge clk);
    instr = op; switches = sw; user_mode = usr;
    link_in = l0; ac_in = a0; mq_in = m0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "busy after accept", busy, 1);
    @(negedge clk);
    chk("R11", "done early (cycle 1)", done, 0);
    if (intrude) begin
      instr = 12'o7200; ac_in = 12'o7777; link_in = ~l0; mq_in = 12'o5555;
      switches = 12'o7777; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R11", "done early (cycle 2)", done, 0);
    @(negedge clk);
    chk("R11", "done at cycle 3", done, 1);
    chk(tag, "link", link_out, el);
    chk(tag, "ac", ac_out, ea);
    chk(tag, "mq", mq_out, em);
    chk(tag, "skip", skip_req, esk);
    chk(tag, "halt", halt_req, eh);
    chk(tag, "trap", user_trap, et);
    @(negedge clk);
    chk("R11", "done single pulse", done, 0);
    chk("R11", "idle after done", busy, 0);
  endtask

  task automatic t_reset();
    chk("R1", "link", link_out, 0);
    chk("R1", "ac", ac_out, 0);
    chk("R1", "mq", mq_out, 0);
    chk("R1", "flags", {skip_req, halt_req, user_trap, busy, done}, 0);
  endtask

  task automatic t_group1_logic();
    run_op("R2", 12'o7240, 0, 0, 0, 12'o1234, 0, 0, 12'o7777, 0, 0, 0, 0, 0);
    run_op("R2", 12'o7120, 0, 0, 0, 12'o1234, 0, 1, 12'o1234, 0, 0, 0, 0, 0);
    run_op("R2", 12'o7300, 0, 0, 1, 12'o4321, 0, 0, 12'o0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_group1_inc();
    run_op("R3", 12'o7001, 0, 0, 0, 12'o7777, 0, 1, 12'o0000, 0, 0, 0, 0, 0);
    run_op("R3", 12'o7041, 0, 0, 0, 12'o0005, 0, 0, 12'o7773, 0, 0, 0, 0, 0);
    // increment before swap: 0077 -> 0100 -> 0001
    run_op("R3", 12'o7003, 0, 0, 0, 12'o0077, 0, 0, 12'o0001, 0, 0, 0, 0, 0);
  endtask

  task automatic t_group1_rot();
    run_op("R4", 12'o7004, 0, 0, 1, 12'o4000, 0, 1, 12'o0001, 0, 0, 0, 0, 0);
    run_op("R4", 12'o7006, 0, 0, 1, 12'o2001, 0, 1, 12'o0006, 0, 0, 0, 0, 0);
    run_op("R4", 12'o7010, 0, 0, 0, 12'o0001, 0, 1, 12'o0000, 0, 0, 0, 0, 0);
    run_op("R4", 12'o7012, 0, 0, 1, 12'o0003, 0, 1, 12'o6000, 0, 0, 0, 0, 0);
    run_op("R4", 12'o7002, 0, 0, 1, 12'o1234, 0, 1, 12'o3412, 0, 0, 0, 0, 0);
    run_op("R4", 12'o7014, 0, 0, 1, 12'o1234, 0, 1, 12'o1234, 0, 0, 0, 0, 0);
  endtask

  task automatic t_group2_skip();
    run_op("R5", 12'o7500, 0, 0, 0, 12'o4000, 0, 0, 12'o4000, 0, 1, 0, 0, 0);
    run_op("R5", 12'o7700, 0, 0, 0, 12'o4000, 0, 0, 12'o0000, 0, 1, 0, 0, 0);
    run_op("R5", 12'o7440, 0, 0, 0, 12'o0001, 0, 0, 12'o0001, 0, 0, 0, 0, 0);
    run_op("R5", 12'o7450, 0, 0, 0, 12'o0001, 0, 0, 12'o0001, 0, 1, 0, 0, 0);
    run_op("R5", 12'o7420, 0, 0, 1, 12'o0000, 0, 1, 12'o0000, 0, 1, 0, 0, 0);
    run_op("R5", 12'o7410, 0, 0, 0, 12'o0000, 0, 0, 12'o0000, 0, 1, 0, 0, 0);
  endtask

  task automatic t_group2_priv();
    run_op("R6", 12'o7604, 12'o5252, 0, 0, 12'o1111, 0, 0, 12'o5252, 0, 0, 0, 0, 0);
    run_op("R6", 12'o7404, 12'o0660, 0, 0, 12'o1111, 0, 0, 12'o1771, 0, 0, 0, 0, 0);
    run_op("R7", 12'o7402, 0, 0, 0, 12'o0042, 0, 0, 12'o0042, 0, 0, 1, 0, 0);
    run_op("R8", 12'o7406, 12'o7777, 1, 0, 12'o0001, 0, 0, 12'o0001, 0, 0, 0, 1, 0);
    run_op("R8", 12'o7402, 0, 1, 0, 12'o0001, 0, 0, 12'o0001, 0, 0, 0, 1, 0);
  endtask

  task automatic t_group3();
    run_op("R9", 12'o7421, 0, 0, 0, 12'o1234, 12'o0000, 0, 12'o1234, 12'o1234, 0, 0, 0, 0);
    run_op("R9", 12'o7441, 0, 0, 0, 12'o1200, 12'o0034, 0, 12'o1234, 12'o0034, 0, 0, 0, 0);
    run_op("R9", 12'o7501, 0, 0, 0, 12'o1111, 12'o2222, 0, 12'o2222, 12'o2222, 0, 0, 0, 0);
    run_op("R9", 12'o7521, 0, 0, 0, 12'o0000, 12'o0017, 0, 12'o0017, 12'o0017, 0, 0, 0, 0);
    run_op("R9", 12'o7641, 0, 0, 0, 12'o7777, 12'o0070, 0, 12'o0070, 12'o0070, 0, 0, 0, 0);
    run_op("R10", 12'o7741, 0, 0, 0, 12'o1234, 12'o4321, 0, 12'o0000, 12'o0000, 0, 0, 0, 0);
  endtask

  task automatic t_busy_start();
    run_op("R11", 12'o7001, 0, 0, 0, 12'o0005, 12'o0003, 0, 12'o0006, 12'o0003, 0, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_group1_logic();
    t_group1_inc();
    t_group1_rot();
    t_group2_skip();
    t_group2_priv();
    t_group3();
    t_busy_start();
    wrap_up();
  end

endmodule